// File: doc/BRIEF.md
# Flash Bus Command Sequence Decoder

This block sits behind the write strobe of an asynchronous flash-style bus, after the strobe has been synchronised to the core clock. It recognises the unlock-protected command sequences that software writes to the device. For each command it accepts, it raises a single-cycle request to the program/erase engine. The request carries the command kind, the address and bank captured during the write, and the data byte.

The block also keeps the device mode: normal read, identification, single-pulse program, and erase-suspended. Single-pulse program mode is entered once through a six-write sequence. From then on every bus write becomes a program request, including writes whose data is an erase, suspend or resume code. Only a reset leaves this mode. The memory array, the operation timing and the busy source are outside the block. The busy source arrives as an input flag and masks writes while an embedded program is running.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset `mode` is 0 (read), `cmd_valid` is 0, and the sequence tracker is idle.
- R2: The writes AA@555, 55@2AA, A0@555 followed by any fourth write raise `cmd_valid` for one cycle with `cmd_op`=1 (program). `cmd_addr` and `cmd_bank` are the values held on `addr`/`bank` when the fourth strobe fell, and `cmd_data` is the byte on `data` when it rose. `cmd_valid` appears in the clock cycle after the rising strobe edge is registered.
- R3: Address bit 11 plays no part in matching an unlock cycle, so D55 matches 555 and AAA matches 2AA.
- R4: The prefix AA@555, 55@2AA, 80@555, AA@555, 55@2AA, followed by 10@555, gives `cmd_op`=2 (chip erase). The same prefix followed by 30 at any address gives `cmd_op`=3 (sector erase), with that address and bank.
- R5: The same five-write prefix followed by 60 at any address gives `cmd_op`=4 (sector lock), with that address.
- R6: The five-write prefix followed by A0@555 sets `mode`=2 (single-pulse) and issues no request. In that mode every write gives `cmd_op`=1 with its own address and data, whatever the data byte. Only reset returns `mode` to 0.
- R7: AA@555, 55@2AA, 90@555 in read mode sets `mode`=1 (identification). That mode is left to `mode`=0 either by a single F0 write at any address or by AA@555, 55@2AA, F0@555. Neither entry nor exit issues a request.
- R8: A single B0 write at any address in read mode gives `cmd_op`=5 (suspend) and sets `mode`=3. A single 30 write while `mode`=3 gives `cmd_op`=6 (resume) with `cmd_bank` taken from the `bank` input and returns `mode` to 0.
- R9: While `mode`=3, a complete chip-erase or sector-erase sequence issues no request. A program sequence is still accepted.
- R10: A write whose strobe rises while `prog_busy` is 1 issues no request and leaves the sequence position unchanged.
- R11: A write that does not match the next expected cycle returns the tracker to idle without a request. The rest of the interrupted sequence then issues nothing.
- R12: `cmd_valid` is never high on two consecutive cycles, and each write produces at most one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset; also the only exit from single-pulse mode |
| wr_n | input | 1 | Synchronised write strobe, active low |
| addr | input | 12 | Low bus address, captured on the falling strobe |
| bank | input | 2 | Top address bits selecting the plane, captured on the falling strobe |
| data | input | 8 | Data byte, taken on the rising strobe |
| prog_busy | input | 1 | High while an embedded program runs; masks writes |
| cmd_valid | output | 1 | One-cycle request strobe to the program/erase engine |
| cmd_op | output | 3 | Request kind: 1 program, 2 chip erase, 3 sector erase, 4 sector lock, 5 suspend, 6 resume, 0 none |
| cmd_addr | output | 12 | Address of the write that completed the request |
| cmd_bank | output | 2 | Bank of the write that completed the request |
| cmd_data | output | 8 | Data of the write that completed the request |
| mode | output | 2 | 0 read, 1 identification, 2 single-pulse program, 3 erase-suspended |

## Verification
The decoder is driven with every complete sequence. Bit 11 is set on some unlock writes to show that this bit is ignored during matching. The same five-write prefix is ended with 10, 30, 60 and A0, which checks that only the final byte selects chip erase, sector erase, lock or the mode switch. A sequence broken by one wrong byte, and then continued, shows that the tracker really drops back to idle and does not resynchronise. Erase codes sent in suspended mode and in single-pulse mode show that the same byte leads to a different outcome depending on the mode. A busy-masked fourth write followed by an unmasked one shows that the busy flag freezes the sequence rather than aborting it.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  // Low address bits compared during unlock cycles; higher bits are ignored.
  localparam int MATCH_W = 11;
  localparam logic [MATCH_W-1:0] ADR_KEY_A = 11'h555;
  localparam logic [MATCH_W-1:0] ADR_KEY_B = 11'h2AA;

  localparam logic [7:0] BYTE_KEY_A   = 8'hAA;
  localparam logic [7:0] BYTE_KEY_B   = 8'h55;
  localparam logic [7:0] BYTE_WRITE   = 8'hA0;
  localparam logic [7:0] BYTE_ARM     = 8'h80;
  localparam logic [7:0] BYTE_ID_IN   = 8'h90;
  localparam logic [7:0] BYTE_ID_OUT  = 8'hF0;
  localparam logic [7:0] BYTE_WHOLE   = 8'h10;
  localparam logic [7:0] BYTE_REGION  = 8'h30;
  localparam logic [7:0] BYTE_FREEZE  = 8'h60;
  localparam logic [7:0] BYTE_PAUSE   = 8'hB0;

  typedef enum logic [2:0] {
    OP_NONE         = 3'd0,
    OP_PROGRAM      = 3'd1,
    OP_CHIP_ERASE   = 3'd2,
    OP_SECTOR_ERASE = 3'd3,
    OP_SECTOR_LOCK  = 3'd4,
    OP_SUSPEND      = 3'd5,
    OP_RESUME       = 3'd6
  } cmd_op_e;

  typedef enum logic [1:0] {
    MODE_READ      = 2'd0,
    MODE_IDENT     = 2'd1,
    MODE_SINGLE    = 2'd2,
    MODE_SUSPENDED = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_KEY1   = 3'd1,
    SQ_KEY2   = 3'd2,
    SQ_WORD   = 3'd3,
    SQ_ARMED  = 3'd4,
    SQ_KEY3   = 3'd5,
    SQ_KEY4   = 3'd6
  } seq_e;

  function automatic logic at_key_a(input logic [MATCH_W-1:0] a);
    return a == ADR_KEY_A;
  endfunction

  function automatic logic at_key_b(input logic [MATCH_W-1:0] a);
    return a == ADR_KEY_B;
  endfunction

  function automatic logic is_erase_op(input cmd_op_e op);
    return (op == OP_CHIP_ERASE) || (op == OP_SECTOR_ERASE);
  endfunction

endpackage

// File: rtl/fcd_strobe_edge.sv
module fcd_strobe_edge #(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] bank,
  output logic              wr_fall,
  output logic              wr_rise,
  output logic [ADDR_W-1:0] addr_lat,
  output logic [BANK_W-1:0] bank_lat
);

  logic wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b1;
    end else begin
      wr_q <= wr_n;
    end
  end

  assign wr_fall = wr_q & ~wr_n;
  assign wr_rise = ~wr_q & wr_n;

  // Address and bank are held from the falling strobe edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_lat <= '0;
      bank_lat <= '0;
    end else if (wr_fall) begin
      addr_lat <= addr;
      bank_lat <= bank;
    end
  end

  // R12: two rising edges are always separated by at least one low sample.
  p_rise_spacing_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rise |=> !wr_rise);

endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_rise,
  input  logic              prog_busy,
  input  logic [ADDR_W-1:0] addr_lat,
  input  logic [BANK_W-1:0] bank_lat,
  input  logic [DATA_W-1:0] data,
  input  mode_e             mode_cur,
  output logic              mode_set,
  output mode_e             mode_val,
  output seq_e              seq_state,
  output logic              cmd_valid,
  output cmd_op_e           cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [DATA_W-1:0] cmd_data
);

  localparam int CODE_W = 8;

  logic               accept;
  logic [MATCH_W-1:0] key_bits;
  logic [CODE_W-1:0]  code;
  logic               first_ok;
  logic               second_ok;
  seq_e               state_nxt;
  logic               issue;
  cmd_op_e            issue_op;

  assign accept    = wr_rise & ~prog_busy;
  assign key_bits  = addr_lat[MATCH_W-1:0];
  assign code      = data[CODE_W-1:0];
  assign first_ok  = at_key_a(key_bits);
  assign second_ok = at_key_b(key_bits);

  always_comb begin
    state_nxt = seq_state;
    issue     = 1'b0;
    issue_op  = OP_NONE;
    mode_set  = 1'b0;
    mode_val  = mode_cur;
    if (accept) begin
      if (mode_cur == MODE_SINGLE) begin
        issue     = 1'b1;
        issue_op  = OP_PROGRAM;
        state_nxt = SQ_IDLE;
      end else begin
        state_nxt = SQ_IDLE;
        unique case (seq_state)
          SQ_IDLE: begin
            if (first_ok && code == BYTE_KEY_A) begin
              state_nxt = SQ_KEY1;
            end else if (code == BYTE_ID_OUT && mode_cur == MODE_IDENT) begin
              mode_set = 1'b1;
              mode_val = MODE_READ;
            end else if (code == BYTE_PAUSE && mode_cur == MODE_READ) begin
              issue    = 1'b1;
              issue_op = OP_SUSPEND;
              mode_set = 1'b1;
              mode_val = MODE_SUSPENDED;
            end else if (code == BYTE_REGION && mode_cur == MODE_SUSPENDED) begin
              issue    = 1'b1;
              issue_op = OP_RESUME;
              mode_set = 1'b1;
              mode_val = MODE_READ;
            end
          end
          SQ_KEY1: begin
            if (second_ok && code == BYTE_KEY_B) state_nxt = SQ_KEY2;
          end
          SQ_KEY2: begin
            if (first_ok) begin
              case (code)
                BYTE_WRITE: state_nxt = SQ_WORD;
                BYTE_ARM:   state_nxt = SQ_ARMED;
                BYTE_ID_IN: begin
                  if (mode_cur == MODE_READ) begin
                    mode_set = 1'b1;
                    mode_val = MODE_IDENT;
                  end
                end
                BYTE_ID_OUT: begin
                  if (mode_cur == MODE_IDENT) begin
                    mode_set = 1'b1;
                    mode_val = MODE_READ;
                  end
                end
                default: state_nxt = SQ_IDLE;
              endcase
            end
          end
          SQ_WORD: begin
            issue    = 1'b1;
            issue_op = OP_PROGRAM;
          end
          SQ_ARMED: begin
            if (first_ok && code == BYTE_KEY_A) state_nxt = SQ_KEY3;
          end
          SQ_KEY3: begin
            if (second_ok && code == BYTE_KEY_B) state_nxt = SQ_KEY4;
          end
          SQ_KEY4: begin
            case (code)
              BYTE_WHOLE: begin
                if (first_ok && mode_cur != MODE_SUSPENDED) begin
                  issue    = 1'b1;
                  issue_op = OP_CHIP_ERASE;
                end
              end
              BYTE_REGION: begin
                if (mode_cur != MODE_SUSPENDED) begin
                  issue    = 1'b1;
                  issue_op = OP_SECTOR_ERASE;
                end
              end
              BYTE_FREEZE: begin
                issue    = 1'b1;
                issue_op = OP_SECTOR_LOCK;
              end
              BYTE_WRITE: begin
                if (first_ok && mode_cur != MODE_SUSPENDED) begin
                  mode_set = 1'b1;
                  mode_val = MODE_SINGLE;
                end
              end
              default: state_nxt = SQ_IDLE;
            endcase
          end
          default: state_nxt = SQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_state <= SQ_IDLE;
    end else begin
      seq_state <= state_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_op    <= OP_NONE;
      cmd_addr  <= '0;
      cmd_bank  <= '0;
      cmd_data  <= '0;
    end else begin
      cmd_valid <= issue;
      cmd_op    <= issue ? issue_op : OP_NONE;
      if (issue) begin
        cmd_addr <= addr_lat;
        cmd_bank <= bank_lat;
        cmd_data <= data;
      end
    end
  end

  // R10: a masked write neither issues nor advances the tracker.
  p_busy_masks_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && prog_busy) |=> (!cmd_valid && $stable(seq_state)));

  // R12: a request is a single-cycle pulse.
  p_single_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R11: without an accepted write the tracker holds its position.
  p_hold_without_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_rise |=> $stable(seq_state));

endmodule

// File: rtl/fcd_mode.sv
module fcd_mode
  import fcd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  mode_set,
  input  mode_e mode_val,
  output mode_e mode_cur
);

  // Single-pulse mode is sticky: no request can move the mode out of it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_cur <= MODE_READ;
    end else if (mode_set && mode_cur != MODE_SINGLE) begin
      mode_cur <= mode_val;
    end
  end

  // R6: only reset leaves single-pulse mode.
  p_single_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cur == MODE_SINGLE) |=> (mode_cur == MODE_SINGLE));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] bank,
  input  logic [DATA_W-1:0] data,
  input  logic              prog_busy,
  output logic              cmd_valid,
  output logic [2:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [DATA_W-1:0] cmd_data,
  output logic [1:0]        mode
);

  logic              wr_fall;
  logic              wr_rise;
  logic [ADDR_W-1:0] addr_lat;
  logic [BANK_W-1:0] bank_lat;
  logic              mode_set;
  mode_e             mode_val;
  mode_e             mode_cur;
  seq_e              seq_state;
  cmd_op_e           op_int;

  fcd_strobe_edge #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_n     (wr_n),
    .addr     (addr),
    .bank     (bank),
    .wr_fall  (wr_fall),
    .wr_rise  (wr_rise),
    .addr_lat (addr_lat),
    .bank_lat (bank_lat)
  );

  fcd_seq #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_rise   (wr_rise),
    .prog_busy (prog_busy),
    .addr_lat  (addr_lat),
    .bank_lat  (bank_lat),
    .data      (data),
    .mode_cur  (mode_cur),
    .mode_set  (mode_set),
    .mode_val  (mode_val),
    .seq_state (seq_state),
    .cmd_valid (cmd_valid),
    .cmd_op    (op_int),
    .cmd_addr  (cmd_addr),
    .cmd_bank  (cmd_bank),
    .cmd_data  (cmd_data)
  );

  fcd_mode u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_set (mode_set),
    .mode_val (mode_val),
    .mode_cur (mode_cur)
  );

  assign cmd_op = op_int;
  assign mode   = mode_cur;

  // R9: no erase request leaves the block while an erase is suspended.
  p_no_erase_when_suspended_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && is_erase_op(op_int)) |-> (mode_cur != MODE_SUSPENDED));

  // R6: in single-pulse mode every request is a program.
  p_single_only_program_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && mode_cur == MODE_SINGLE) |-> (op_int == OP_PROGRAM));

  // R8: a resume request coincides with the return to read mode.
  p_resume_to_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op_int == OP_RESUME) |-> (mode_cur == MODE_READ));

  // R1: the tracker sits idle whenever a request has just been issued from it.
  p_idle_after_request_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (seq_state == SQ_IDLE));

endmodule

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/1ps
module flash_cmd_decoder_test;

  typedef struct packed {
    logic [11:0] a;
    logic [1:0]  b;
    logic [7:0]  d;
    logic        bz;
    logic [2:0]  op;
    logic [1:0]  md;
    logic [3:0]  rq;
  } vec_t;

  function automatic vec_t v(input logic [11:0] a, input logic [1:0] b,
                             input logic [7:0] d, input logic bz,
                             input logic [2:0] op, input logic [1:0] md,
                             input logic [3:0] rq);
    vec_t t;
    t.a = a; t.b = b; t.d = d; t.bz = bz; t.op = op; t.md = md; t.rq = rq;
    return t;
  endfunction

  localparam int NV = 64;
  // op: 1 program, 2 chip erase, 3 sector erase, 4 lock, 5 suspend, 6 resume
  // mode: 0 read, 1 ident, 2 single-pulse, 3 suspended
  localparam vec_t VECS [NV] = '{
    // R2 word program
    v(12'h555,0,8'hAA,0,0,0,2), v(12'h2AA,0,8'h55,0,0,0,2), v(12'h555,0,8'hA0,0,0,0,2),
    v(12'h123,2,8'h3C,0,1,0,2),
    // R3 bit 11 ignored, R4 chip erase
    v(12'hD55,0,8'hAA,0,0,0,3), v(12'hAAA,0,8'h55,0,0,0,3), v(12'h555,0,8'h80,0,0,0,4),
    v(12'h555,0,8'hAA,0,0,0,4), v(12'h2AA,0,8'h55,0,0,0,4), v(12'h555,0,8'h10,0,2,0,4),
    // R4 sector erase
    v(12'h555,0,8'hAA,0,0,0,4), v(12'h2AA,0,8'h55,0,0,0,4), v(12'h555,0,8'h80,0,0,0,4),
    v(12'h555,0,8'hAA,0,0,0,4), v(12'h2AA,0,8'h55,0,0,0,4), v(12'h456,1,8'h30,0,3,0,4),
    // R5 sector lock
    v(12'h555,0,8'hAA,0,0,0,5), v(12'h2AA,0,8'h55,0,0,0,5), v(12'h555,0,8'h80,0,0,0,5),
    v(12'h555,0,8'hAA,0,0,0,5), v(12'h2AA,0,8'h55,0,0,0,5), v(12'h789,0,8'h60,0,4,0,5),
    // R8 suspend, R9 erase refused while suspended
    v(12'h000,0,8'hB0,0,5,3,8),
    v(12'h555,0,8'hAA,0,0,3,9), v(12'h2AA,0,8'h55,0,0,3,9), v(12'h555,0,8'h80,0,0,3,9),
    v(12'h555,0,8'hAA,0,0,3,9), v(12'h2AA,0,8'h55,0,0,3,9), v(12'h456,0,8'h30,0,0,3,9),
    // R9 program still accepted while suspended
    v(12'h555,0,8'hAA,0,0,3,9), v(12'h2AA,0,8'h55,0,0,3,9), v(12'h555,0,8'hA0,0,0,3,9),
    v(12'h0F0,0,8'h5A,0,1,3,9),
    // R8 resume with bank
    v(12'h000,3,8'h30,0,6,0,8),
    // R7 ident entry, single F0 exit, three-write exit
    v(12'h555,0,8'hAA,0,0,0,7), v(12'h2AA,0,8'h55,0,0,0,7), v(12'h555,0,8'h90,0,0,1,7),
    v(12'hABC,0,8'hF0,0,0,0,7),
    v(12'h555,0,8'hAA,0,0,0,7), v(12'h2AA,0,8'h55,0,0,0,7), v(12'h555,0,8'h90,0,0,1,7),
    v(12'h555,0,8'hAA,0,0,1,7), v(12'h2AA,0,8'h55,0,0,1,7), v(12'h555,0,8'hF0,0,0,0,7),
    // R11 broken sequence
    v(12'h555,0,8'hAA,0,0,0,11), v(12'h2AA,0,8'h56,0,0,0,11), v(12'h2AA,0,8'h55,0,0,0,11),
    v(12'h555,0,8'hA0,0,0,0,11), v(12'h100,0,8'h77,0,0,0,11),
    // R10 busy-masked write then the real one
    v(12'h555,0,8'hAA,0,0,0,10), v(12'h2AA,0,8'h55,0,0,0,10), v(12'h555,0,8'hA0,0,0,0,10),
    v(12'h200,0,8'h12,1,0,0,10), v(12'h201,1,8'h34,0,1,0,10),
    // R6 single-pulse entry and writes
    v(12'h555,0,8'hAA,0,0,0,6), v(12'h2AA,0,8'h55,0,0,0,6), v(12'h555,0,8'h80,0,0,0,6),
    v(12'h555,0,8'hAA,0,0,0,6), v(12'h2AA,0,8'h55,0,0,0,6), v(12'h555,0,8'hA0,0,0,2,6),
    v(12'h010,0,8'hB0,0,1,2,6), v(12'h020,2,8'h30,0,1,2,6), v(12'h030,0,8'hF0,0,1,2,6),
    v(12'h555,0,8'hAA,0,1,2,6)
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_n;
  logic [11:0] addr;
  logic [1:0]  bank;
  logic [7:0]  data;
  logic        prog_busy;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [11:0] cmd_addr;
  logic [1:0]  cmd_bank;
  logic [7:0]  cmd_data;
  logic [1:0]  mode;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  flash_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .addr(addr), .bank(bank),
    .data(data), .prog_busy(prog_busy), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_bank(cmd_bank),
    .cmd_data(cmd_data), .mode(mode)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One bus write; returns at the negedge where the request (if any) is visible.
  task automatic bus_write(input logic [11:0] a, input logic [1:0] b,
                           input logic [7:0] d, input logic bz);
    addr = a; bank = b; wr_n = 1'b0; data = 8'h00;
    repeat (2) @(negedge clk);
    data = d; prog_busy = bz; wr_n = 1'b1;
    @(negedge clk);
    prog_busy = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; wr_n = 1'b1; addr = '0; bank = '0; data = '0; prog_busy = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "reset mode", {30'd0, mode}, 32'd0);
    check("R1", "reset valid", {31'd0, cmd_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "mode after release", {30'd0, mode}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d(v%0d)", VECS[i].rq, i);
      bus_write(VECS[i].a, VECS[i].b, VECS[i].d, VECS[i].bz);
      check(tag, "valid", {31'd0, cmd_valid}, {31'd0, VECS[i].op != 3'd0});
      check(tag, "mode", {30'd0, mode}, {30'd0, VECS[i].md});
      if (VECS[i].op != 3'd0) begin
        check(tag, "op", {29'd0, cmd_op}, {29'd0, VECS[i].op});
        if (VECS[i].op == 3'd6) begin
          check(tag, "bank", {30'd0, cmd_bank}, {30'd0, VECS[i].b});
        end else if (VECS[i].op != 3'd5 && VECS[i].op != 3'd2) begin
          check(tag, "addr", {20'd0, cmd_addr}, {20'd0, VECS[i].a});
          check(tag, "bank", {30'd0, cmd_bank}, {30'd0, VECS[i].b});
        end
        if (VECS[i].op == 3'd1) begin
          check(tag, "data", {24'd0, cmd_data}, {24'd0, VECS[i].d});
        end
        @(negedge clk);
        check("R12", "valid drops after one cycle", {31'd0, cmd_valid}, 32'd0);
      end
    end

    // R6: only reset leaves single-pulse mode; afterwards B0 is a suspend again.
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "reset from single-pulse, mode", {30'd0, mode}, 32'd0);
    check("R1", "reset from single-pulse, valid", {31'd0, cmd_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    bus_write(12'h040, 2'd0, 8'hB0, 1'b0);
    check("R6", "B0 after reset is suspend", {29'd0, cmd_op}, 32'd5);
    check("R8", "mode after suspend", {30'd0, mode}, 32'd3);

    // R11: a key byte at the wrong address aborts; the trailing program does nothing.
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    bus_write(12'h555, 2'd0, 8'hAA, 1'b0);
    bus_write(12'h554, 2'd0, 8'h55, 1'b0);
    bus_write(12'h555, 2'd0, 8'hA0, 1'b0);
    bus_write(12'h300, 2'd0, 8'h99, 1'b0);
    check("R11", "wrong unlock address gives no request", {31'd0, cmd_valid}, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule